// File: doc/BRIEF.md
# Byte-Lane Data Memory Controller

This block is a 256-byte synchronous data memory with a 32-bit data path. Storage is split into four 64-entry banks, one bank per byte lane of the data word. The read path and the write path each have their own enable, address and access size, so a read and a write can be issued in the same cycle. Each access is a byte, a halfword or a word.

Bytes are laid out big-endian: the lowest byte address of a word lives in bits 31:24. On a read, the selected byte or halfword is moved down to the low bits of the read data and the unused upper bits are zero. On a write, only the banks covered by the access are enabled and the other lanes keep their contents. The block answers only inside a 256-byte window that starts at a base address given as a parameter. By default this window sits just above a 1 KiB instruction region. Memory contents are not cleared by reset, and the ready output is always high.

Top module: `bytelane_dmem`

## Requirements
- R1: After reset and before the first read, `rd_data` is zero. Reset does not clear the storage.
- R2: A read that is sampled with `rd_en` high on a rising edge gives its result on `rd_data` after that edge, so it can be sampled at the next rising edge. The size code is 00 for byte, 01 for halfword, 10 for word, and 11 is handled as word. A word read ignores address bits 1:0.
- R3: Big-endian byte layout. Byte offset 0, 1, 2 and 3 of a word are held in word bits 31:24, 23:16, 15:8 and 7:0. A byte read returns the selected byte in `rd_data[7:0]`, with bits 31:8 zero.
- R4: A halfword read picks word bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. Address bit 0 is ignored. The halfword is returned in `rd_data[15:0]`, with bits 31:16 zero.
- R5: A byte write stores `wr_data[7:0]` in the addressed byte only. The other three bytes of that word keep their contents.
- R6: A halfword write stores `wr_data[15:0]` in the half selected by address bit 1, with address bit 0 ignored. The other half keeps its contents.
- R7: A word write stores all 32 bits of `wr_data` at the word address, with address bits 1:0 ignored.
- R8: An address outside the window [BASE_ADDR, BASE_ADDR+256) is ignored. A write there changes no stored byte, and a read there returns zero.
- R9: `rd_data` holds its value during cycles in which `rd_en` is low.
- R10: If a read and a write hit the same location in one cycle, the read returns the contents from before the write, and the write is committed.
- R11: `ready` is high at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 32 | Read byte address |
| rd_size | input | 2 | Read size code (00 byte, 01 half, 10/11 word) |
| rd_data | output | 32 | Right-aligned read result |
| wr_en | input | 1 | Write request |
| wr_addr | input | 32 | Write byte address |
| wr_size | input | 2 | Write size code (00 byte, 01 half, 10/11 word) |
| wr_data | input | 32 | Write data, right-aligned for byte and halfword |
| ready | output | 1 | Always high: every access finishes in one cycle |

## Verification
Reads have one cycle of latency. The bench drives a request just after a falling edge, and the bank and alignment registers load at the next rising edge. The bench then compares `rd_data` at the following falling edge, before it drives the next request. A write becomes visible to any read sampled at a later rising edge. For this reason the reference model computes the expected read value first and applies the same cycle's write afterwards, which matches the read-first rule for same-cycle collisions. In cycles with no read, the expected value is the one from the previous read. This keeps the hold rule under check during the random traffic.

// File: rtl/bytelane_dmem_pkg.sv
// Shared types for the byte-lane data memory.
// Assumes a fixed 32-bit data word split into four byte lanes.
package bytelane_dmem_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int BOFF_W  = $clog2(LANES);

    // Access size codes; the unused code falls back to a word access.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/bldm_decode.sv
// Address decoder for one access path.
// Checks that the address is inside the window and splits it into a bank
// index and a byte offset. It also builds the big-endian lane-enable mask.
// Assumes BASE_ADDR is word aligned.
module bldm_decode
    import bytelane_dmem_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_0400,
    parameter int          TOTAL     = 256,
    parameter int          IDX_W     = 6
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [BOFF_W-1:0] boff,
    output logic [LANES-1:0]  lane_mask
);

    logic [ADDR_W-1:0] off_full;
    logic              in_window;

    // Offset from the base and window test.
    always_comb begin
        off_full  = addr - ADDR_W'(BASE_ADDR);
        in_window = (addr >= ADDR_W'(BASE_ADDR)) && (off_full < ADDR_W'(TOTAL));
        hit       = req && in_window;
        idx       = off_full[IDX_W+BOFF_W-1:BOFF_W];
        boff      = off_full[BOFF_W-1:0];
    end

    // Lane enables: byte offset 0 lives in the most significant lane.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: lane_mask = LANES'(4'b1000 >> boff);
            SZ_HALF: lane_mask = boff[1] ? LANES'(4'b0011) : LANES'(4'b1100);
            default: lane_mask = '1;
        endcase
        if (!hit) lane_mask = '0;
    end

endmodule

// File: rtl/bldm_bank.sv
// One byte-wide storage bank with a registered read port and a write port.
// The read is read-first: on a same-cycle collision the read returns the
// stored value from before the write. The contents have no reset.
module bldm_bank #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [7:0]       w_byte,
    input  logic             re,
    input  logic [IDX_W-1:0] r_idx,
    output logic [7:0]       r_byte
);

    logic [7:0] mem [DEPTH];

    // Commit a write to the addressed entry.
    always_ff @(posedge clk) begin
        if (we) mem[w_idx] <= w_byte;
    end

    // Register the addressed entry on a read.
    always_ff @(posedge clk) begin
        if (re) r_byte <= mem[r_idx];
    end

endmodule

// File: rtl/bldm_align.sv
// Read alignment: moves the selected byte or halfword of the registered
// word down to the low bits and zeroes the rest. Outputs zero for a miss.
module bldm_align
    import bytelane_dmem_pkg::*;
(
    input  logic [WORD_W-1:0] word_q,
    input  logic [1:0]        size_q,
    input  logic [BOFF_W-1:0] boff_q,
    input  logic              hit_q,
    output logic [WORD_W-1:0] data_out
);

    logic [WORD_W-1:0] shifted;

    // Bring the big-endian byte down to bits 7:0, or select a halfword.
    always_comb begin
        shifted = word_q >> (8 * (LANES - 1 - int'(boff_q)));
        unique case (acc_size_e'(size_q))
            SZ_BYTE: data_out = {24'h0, shifted[7:0]};
            SZ_HALF: data_out = boff_q[1] ? {16'h0, word_q[15:0]} : {16'h0, word_q[31:16]};
            default: data_out = word_q;
        endcase
        if (!hit_q) data_out = '0;
    end

endmodule

// File: rtl/bytelane_dmem.sv
// Top of the byte-lane data memory.
// Four byte-wide banks hold a big-endian 256-byte window at BASE_ADDR.
// The read path and the write path are independent and may act in the same
// cycle. Reads take one cycle. Storage is not initialised.
module bytelane_dmem
    import bytelane_dmem_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          IMEM_BYTES = 1024,
    parameter logic [31:0] BASE_ADDR  = 32'(IMEM_BYTES),
    parameter int          BANK_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       wr_data,
    output logic              ready
);

    localparam int TOTAL = LANES * BANK_DEPTH;
    localparam int IDX_W = $clog2(BANK_DEPTH);

    logic              r_hit, w_hit;
    logic [IDX_W-1:0]  r_idx, w_idx;
    logic [BOFF_W-1:0] r_boff, w_boff;
    logic [LANES-1:0]  r_mask, w_mask;
    logic [WORD_W-1:0] w_spread;
    logic [WORD_W-1:0] word_q;
    logic              hit_q;
    logic [1:0]        size_q;
    logic [BOFF_W-1:0] boff_q;

    bldm_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .TOTAL(TOTAL), .IDX_W(IDX_W)
    ) u_rdec (
        .req(rd_en), .addr(rd_addr), .size(rd_size),
        .hit(r_hit), .idx(r_idx), .boff(r_boff), .lane_mask(r_mask)
    );

    bldm_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .TOTAL(TOTAL), .IDX_W(IDX_W)
    ) u_wdec (
        .req(wr_en), .addr(wr_addr), .size(wr_size),
        .hit(w_hit), .idx(w_idx), .boff(w_boff), .lane_mask(w_mask)
    );

    // Copy right-aligned write data to every lane the size can reach.
    always_comb begin
        unique case (acc_size_e'(wr_size))
            SZ_BYTE: w_spread = {LANES{wr_data[7:0]}};
            SZ_HALF: w_spread = {2{wr_data[15:0]}};
            default: w_spread = wr_data;
        endcase
    end

    // One bank per lane; lane k holds word bits 8k+7:8k.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        bldm_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
            .clk    (clk),
            .we     (w_mask[k]),
            .w_idx  (w_idx),
            .w_byte (w_spread[8*k +: 8]),
            .re     (r_hit),
            .r_idx  (r_idx),
            .r_byte (word_q[8*k +: 8])
        );
    end

    // Keep the read attributes alongside the registered bank data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            size_q <= SZ_WORD;
            boff_q <= '0;
        end else if (rd_en) begin
            hit_q  <= r_hit;
            size_q <= rd_size;
            boff_q <= r_boff;
        end
    end

    bldm_align u_align (
        .word_q(word_q), .size_q(size_q), .boff_q(boff_q), .hit_q(hit_q),
        .data_out(rd_data)
    );

    // Single-cycle memory never stalls the requester.
    assign ready = 1'b1;

    // The read mask and write byte offset are produced for symmetry only.
    logic unused_ok;
    assign unused_ok = ^{r_mask, w_boff};

endmodule

// File: rtl/bldm_checker.sv
// Temporal checks on the ports of bytelane_dmem, bound into every instance.
module bldm_checker #(
    parameter logic [31:0] BASE_ADDR = 32'h0000_0400,
    parameter int          TOTAL     = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [31:0] rd_addr,
    input logic [1:0]  rd_size,
    input logic [31:0] rd_data,
    input logic        wr_en,
    input logic [31:0] wr_addr,
    input logic [1:0]  wr_size,
    input logic [31:0] wr_data
);

    logic rd_in;
    assign rd_in = (rd_addr >= BASE_ADDR) && ((rd_addr - BASE_ADDR) < 32'(TOTAL));

    // R8: a read outside the window returns zero.
    p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_in |=> rd_data == 32'h0);

    // R3: a byte read leaves bits 31:8 zero.
    p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_size == 2'b00 |=> rd_data[31:8] == 24'h0);

    // R4: a halfword read leaves bits 31:16 zero.
    p_half_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_size == 2'b01 |=> rd_data[31:16] == 16'h0);

    // R9: with no read, the output holds.
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7: a word written one cycle before a word read of the same word is returned.
    p_word_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_size == 2'b10 && rd_in && $past(wr_en) && $past(wr_size) == 2'b10
        && $past(wr_addr[31:2]) == rd_addr[31:2]
        |=> rd_data == $past(wr_data, 2));

endmodule

bind bytelane_dmem bldm_checker #(.BASE_ADDR(BASE_ADDR), .TOTAL(LANES * BANK_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
);

// File: tb/sim_bytelane_dmem.sv
`timescale 1ns/1ps
module sim_bytelane_dmem;

    localparam logic [31:0] B = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    logic [1:0]  rd_size = '0, wr_size = '0;
    logic [31:0] rd_data;
    logic        ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_exp = '0;
    logic [7:0]  model [256];

    always #4 clk = ~clk;

    bytelane_dmem u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .ready(ready)
    );

    function automatic bit in_win(input logic [31:0] a);
        return (a >= B) && (a - B < 32'd256);
    endfunction

    // Expected read result from the big-endian byte model (R2, R3, R4, R8).
    function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] s);
        int o;
        if (!in_win(a)) return 32'h0;
        o = int'(a - B);
        case (s)
            2'b00:   return {24'h0, model[o]};
            2'b01: begin o = o & 32'hFE; return {16'h0, model[o], model[o+1]}; end
            default: begin o = o & 32'hFC; return {model[o], model[o+1], model[o+2], model[o+3]}; end
        endcase
    endfunction

    // Apply a write to the model (R5, R6, R7, R8).
    task automatic model_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
        int o;
        if (!in_win(a)) return;
        o = int'(a - B);
        case (s)
            2'b00: model[o] = d[7:0];
            2'b01: begin o = o & 32'hFE; model[o] = d[15:8]; model[o+1] = d[7:0]; end
            default: begin
                o = o & 32'hFC;
                model[o] = d[31:24]; model[o+1] = d[23:16];
                model[o+2] = d[15:8]; model[o+3] = d[7:0];
            end
        endcase
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, compare at the next falling edge.
    task automatic step(input bit re, input logic [31:0] ra, input logic [1:0] rs,
                        input bit we, input logic [31:0] wa, input logic [1:0] ws,
                        input logic [31:0] wd, input string req);
        logic [31:0] exp;
        rd_en = re; rd_addr = ra; rd_size = rs;
        wr_en = we; wr_addr = wa; wr_size = ws; wr_data = wd;
        exp = re ? exp_read(ra, rs) : last_exp;   // read-first (R10), hold (R9)
        @(posedge clk);
        if (we) model_write(wa, ws, wd);
        @(negedge clk);
        check(req, rd_data, exp);
        last_exp = exp;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] s, input string req);
        step(1, a, s, 0, 32'h0, 2'b10, 32'h0, req);
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d, input string req);
        step(0, 32'h0, 2'b10, 1, a, s, d, req);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R11 ready during reset", {31'h0, ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 32'h0);
        check("R11 ready after reset", {31'h0, ready}, 32'h1);

        // Fill the whole window with word writes (R7); rd_data must hold (R9).
        for (int i = 0; i < 64; i++) wr(B + 32'(4*i), 2'b10, $urandom, "R9 hold during fill");

        // Directed big-endian layout checks.
        wr(B, 2'b10, 32'h1122_3344, "R7 word write");
        rd(B + 1, 2'b00, "R3 byte offset 1");
        check("R3 literal byte 1", rd_data, 32'h0000_0022);
        rd(B + 0, 2'b00, "R3 byte offset 0");
        check("R3 literal byte 0", rd_data, 32'h0000_0011);
        rd(B + 3, 2'b00, "R3 byte offset 3");
        rd(B + 1, 2'b01, "R4 half upper, bit0 ignored");
        check("R4 literal upper half", rd_data, 32'h0000_1122);
        rd(B + 2, 2'b01, "R4 half lower");
        check("R4 literal lower half", rd_data, 32'h0000_3344);
        rd(B + 3, 2'b10, "R2 word read ignores low bits");
        check("R2 literal word", rd_data, 32'h1122_3344);
        rd(B, 2'b11, "R2 size 11 acts as word");

        wr(B + 1, 2'b00, 32'hFFFF_FFAA, "R5 byte write");
        rd(B, 2'b10, "R5 other lanes kept");
        check("R5 literal", rd_data, 32'h11AA_3344);
        wr(B + 3, 2'b01, 32'h1234_BEEF, "R6 half write bit0 ignored");
        rd(B, 2'b10, "R6 upper half kept");
        check("R6 literal", rd_data, 32'h11AA_BEEF);

        // Out-of-window accesses (R8).
        wr(B + 32'd256, 2'b10, 32'hDEAD_BEEF, "R8 write beyond window");
        wr(B - 32'd4, 2'b10, 32'hDEAD_BEEF, "R8 write below window");
        rd(B, 2'b10, "R8 aliased word untouched");
        check("R8 literal", rd_data, 32'h11AA_BEEF);
        rd(B + 32'd256, 2'b10, "R8 read beyond window is zero");
        rd(B - 32'd1, 2'b00, "R8 read below window is zero");
        rd(B + 32'd255, 2'b00, "R8 last byte in window");

        // Same-cycle read and write (R10).
        step(1, B, 2'b10, 1, B, 2'b10, 32'hCAFE_F00D, "R10 read-first collision");
        check("R10 literal old value", rd_data, 32'h11AA_BEEF);
        rd(B, 2'b10, "R10 write committed");
        check("R10 literal new value", rd_data, 32'hCAFE_F00D);
        step(0, 32'h0, 2'b00, 0, 32'h0, 2'b00, 32'h0, "R9 hold while idle");

        // Constrained random traffic on both paths.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, wa;
            ra = ($urandom % 10 != 0) ? B + ($urandom % 256) :
                 (($urandom % 2) ? B + 32'd256 + ($urandom % 64) : B - 1 - ($urandom % 16));
            wa = ($urandom % 10 != 0) ? B + ($urandom % 256) :
                 (($urandom % 2) ? B + 32'd256 + ($urandom % 64) : B - 1 - ($urandom % 16));
            step(($urandom % 4) != 0, ra, 2'($urandom), ($urandom % 2) == 1, wa, 2'($urandom),
                 $urandom, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end
        check("R11 ready at end", {31'h0, ready}, 32'h1);
        finish_run();
    end

endmodule